// File: doc/BRIEF.md
# Asynchronous Memory Cycle Timing Controller

This block runs read and write cycles on an external asynchronous memory bus (static RAM, NOR flash and similar parts) spread over four chip-select spaces. A requester hands over one access at a time through a valid/ready handshake: an address, a space index, a direction bit and write data. The controller then walks the bus through an optional turnaround gap, a setup phase, a strobe phase and a hold phase. It drives the address, the per-space chip-select lines, the output-enable and write-enable strobes and the write data with its enable. When the access ends it returns the captured read data together with a one-cycle done pulse.

Every space has its own configuration word, so each one can be timed for a different device. The word holds separate setup, strobe and hold widths for reads and for writes, a turnaround width, a bit that makes chip select act as a strobe, and a bit that lets an external wait pin stretch the strobe phase. Every programmed width means its value plus one clock. The configuration of the selected space is sampled when the request is accepted. Configuration words are expected to change only between accesses.

Top module: `amem_cycle_ctrl`

## Requirements
- R1: While reset is held and right after it is released, reqReady is 1, every memCsN bit is 1, memOeN and memWeN are 1, memDataOe is 0 and doneValid is 0.
- R2: For a read, the setup, strobe and hold phases last rdSetup+1, rdStrobe+1 and rdHold+1 cycles. For a write, they last wrSetup+1, wrStrobe+1 and wrHold+1 cycles. The strobe (memOeN for reads, memWeN for writes) is low only in the strobe phase, and the other strobe stays high.
- R3: Space i takes its word from cfgWord[i*29 +: 29], laid out as rdSetup [3:0], rdStrobe [7:4], rdHold [11:8], wrSetup [15:12], wrStrobe [19:16], wrHold [23:20], turnaround [26:24], cs-strobe mode [27] and wait enable [28]. Each access uses only the word of its own space.
- R4: With the cs-strobe bit at 0, memCsN[reqCs] is low in every setup, strobe and hold cycle of the access and in no other cycle. All other memCsN bits stay high.
- R5: With the cs-strobe bit at 1, memCsN[reqCs] is low only in the strobe-phase cycles.
- R6: In every setup, strobe and hold cycle of a write, memDataOe is 1 and memDataOut equals the request's write data. memDataOe is 0 in every cycle of a read and outside accesses.
- R7: For a read, rdData holds the value memDataIn had in the last strobe cycle, and it is valid from the done pulse on.
- R8: When the previous accepted access had a different direction or a different space, turnaround+1 idle cycles follow acceptance before setup, with reqReady low, no chip select, no strobe and no data drive. Turnaround comes from the new access's word. No gap is inserted for the first access after reset, or for a same-direction access to the same space.
- R9: With the wait-enable bit at 1, memWait goes through a two-flop synchronizer. While the synchronized level equals waitPol (1 means high = wait), the strobe phase does not end. If the pin leaves the wait level before the clock edge that ends strobe cycle j, the strobe phase lasts max(strobe+1, j+2) cycles.
- R10: With the wait-enable bit at 0, memWait has no effect, and the strobe phase lasts strobe+1 cycles even when the pin stays at the wait level.
- R11: reqReady is 1 only between accesses, and a request is accepted when reqValid and reqReady are both 1. doneValid is 1 for exactly one cycle, the cycle after the last hold cycle, with reqReady 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | NUM_CS*29 | Packed configuration words, one per space |
| waitPol | input | 1 | Wait pin level that means wait |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCs | input | 2 | Chip-select space index |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| doneValid | output | 1 | One-cycle end-of-access pulse |
| rdData | output | DATA_W | Captured read data |
| memAddr | output | ADDR_W | Memory address pins |
| memCsN | output | NUM_CS | Active-low chip selects |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDataOut | output | DATA_W | Write data to the bus |
| memDataOe | output | 1 | Data pin drive enable |
| memDataIn | input | DATA_W | Read data from the bus |
| memWait | input | 1 | External wait pin |

## Verification
The assertions assume that every space with wait enabled has a strobe field above zero, so that a stretched strobe always has a strobe cycle to hold. They also assume that request fields stay stable while reqValid waits for reqReady, and that configuration words do not move during an access. The bench rewrites configuration words only between the done pulse and the next request. It programs strobe widths of at least one in every space where wait is enabled. It raises the wait pin several cycles ahead of a request and lowers it at a known strobe cycle, so the synchronizer always starts from a settled level.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // accept a request, snapshot request and timing
    logic capture;   // last strobe cycle: sample read data
    logic active;    // setup, strobe or hold phase
    logic strobeOn;  // strobe phase
  } dpCtl_t;

endpackage

// File: rtl/amem_cfg_sel.sv
module amem_cfg_sel #(
  parameter int NUM_CS  = 4,
  parameter int FIELD_W = 4,
  parameter int TA_W    = 3,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int CFG_W  = 6 * FIELD_W + TA_W + 2
) (
  input  logic [NUM_CS*CFG_W-1:0] cfgWord,
  input  logic [CS_W-1:0]         selCs,
  input  logic                    selWrite,
  output logic [FIELD_W-1:0]      setupW,
  output logic [FIELD_W-1:0]      strobeW,
  output logic [FIELD_W-1:0]      holdW,
  output logic [TA_W-1:0]         turnW,
  output logic                    csStrobe,
  output logic                    waitEn
);
  localparam int RD_SETUP_LO  = 0;
  localparam int RD_STROBE_LO = FIELD_W;
  localparam int RD_HOLD_LO   = 2 * FIELD_W;
  localparam int WR_SETUP_LO  = 3 * FIELD_W;
  localparam int WR_STROBE_LO = 4 * FIELD_W;
  localparam int WR_HOLD_LO   = 5 * FIELD_W;
  localparam int TURN_LO      = 6 * FIELD_W;
  localparam int CSS_BIT      = TURN_LO + TA_W;
  localparam int WEN_BIT      = CSS_BIT + 1;

  logic [CFG_W-1:0] words [NUM_CS];
  logic [CFG_W-1:0] sel;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_word
    assign words[g] = cfgWord[g*CFG_W +: CFG_W];
  end

  assign sel = words[selCs];

  always_comb begin
    if (selWrite) begin
      setupW  = sel[WR_SETUP_LO  +: FIELD_W];
      strobeW = sel[WR_STROBE_LO +: FIELD_W];
      holdW   = sel[WR_HOLD_LO   +: FIELD_W];
    end else begin
      setupW  = sel[RD_SETUP_LO  +: FIELD_W];
      strobeW = sel[RD_STROBE_LO +: FIELD_W];
      holdW   = sel[RD_HOLD_LO   +: FIELD_W];
    end
  end

  assign turnW    = sel[TURN_LO +: TA_W];
  assign csStrobe = sel[CSS_BIT];
  assign waitEn   = sel[WEN_BIT];

endmodule

// File: rtl/amem_ctrl.sv
module amem_ctrl
  import amem_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int TA_W    = 3,
  parameter int CS_W    = 2,
  localparam int CNT_W  = (FIELD_W > TA_W) ? FIELD_W : TA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [CS_W-1:0]    reqCs,
  input  logic [FIELD_W-1:0] newSetup,
  input  logic [TA_W-1:0]    newTurn,
  input  logic               lastWrite,
  input  logic [CS_W-1:0]    lastCs,
  input  logic [FIELD_W-1:0] curSetup,
  input  logic [FIELD_W-1:0] curStrobe,
  input  logic [FIELD_W-1:0] curHold,
  input  logic               stall,
  output logic               reqReady,
  output logic               doneValid,
  output dpCtl_t             ctl
);
  phase_e            phase, phaseNx;
  logic [CNT_W-1:0]  cnt, cntNx;
  logic              lastValid;
  logic              doneQ;
  logic              accept;
  logic              needTurn;
  logic              cntZero;
  logic              strobeEnd;

  assign accept    = reqValid && (phase == PH_IDLE);
  assign needTurn  = lastValid && ((reqWrite != lastWrite) || (reqCs != lastCs));
  assign cntZero   = (cnt == '0);
  assign strobeEnd = (phase == PH_STROBE) && cntZero && !stall;

  always_comb begin
    phaseNx = phase;
    cntNx   = cnt;
    unique case (phase)
      PH_IDLE: begin
        if (accept) begin
          if (needTurn) begin
            phaseNx = PH_TURN;
            cntNx   = CNT_W'(newTurn);
          end else begin
            phaseNx = PH_SETUP;
            cntNx   = CNT_W'(newSetup);
          end
        end
      end
      PH_TURN: begin
        if (cntZero) begin
          phaseNx = PH_SETUP;
          cntNx   = CNT_W'(curSetup);
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          phaseNx = PH_STROBE;
          cntNx   = CNT_W'(curStrobe);
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      PH_STROBE: begin
        if (!cntZero) begin
          cntNx = cnt - 1'b1;
        end else if (!stall) begin
          phaseNx = PH_HOLD;
          cntNx   = CNT_W'(curHold);
        end
      end
      PH_HOLD: begin
        if (cntZero) begin
          phaseNx = PH_IDLE;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      default: begin
        phaseNx = PH_IDLE;
        cntNx   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      lastValid <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      phase <= phaseNx;
      cnt   <= cntNx;
      doneQ <= (phase == PH_HOLD) && cntZero;
      if (accept) begin
        lastValid <= 1'b1;
      end
    end
  end

  assign reqReady     = (phase == PH_IDLE);
  assign doneValid    = doneQ;
  assign ctl.load     = accept;
  assign ctl.capture  = strobeEnd;
  assign ctl.active   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign ctl.strobeOn = (phase == PH_STROBE);

endmodule

// File: rtl/amem_dp.sv
module amem_dp
  import amem_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 4,
  parameter int CS_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               reqWrite,
  input  logic [CS_W-1:0]    reqCs,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [FIELD_W-1:0] selSetup,
  input  logic [FIELD_W-1:0] selStrobe,
  input  logic [FIELD_W-1:0] selHold,
  input  logic               selCsStrobe,
  input  logic               selWaitEn,
  input  logic               waitPol,
  input  logic               memWait,
  input  logic [DATA_W-1:0]  memDataIn,
  output logic               curWrite,
  output logic [CS_W-1:0]    curCs,
  output logic [FIELD_W-1:0] curSetup,
  output logic [FIELD_W-1:0] curStrobe,
  output logic [FIELD_W-1:0] curHold,
  output logic               stall,
  output logic [DATA_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [NUM_CS-1:0]  memCsN,
  output logic               memOeN,
  output logic               memWeN,
  output logic [DATA_W-1:0]  memDataOut,
  output logic               memDataOe
);
  logic               writeQ;
  logic [CS_W-1:0]    csQ;
  logic [ADDR_W-1:0]  addrQ;
  logic [DATA_W-1:0]  wdataQ;
  logic [FIELD_W-1:0] setupQ;
  logic [FIELD_W-1:0] strobeQ;
  logic [FIELD_W-1:0] holdQ;
  logic               csStrobeQ;
  logic               waitEnQ;
  logic               waitMeta;
  logic               waitSync;
  logic [DATA_W-1:0]  rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeQ    <= 1'b0;
      csQ       <= '0;
      addrQ     <= '0;
      wdataQ    <= '0;
      setupQ    <= '0;
      strobeQ   <= '0;
      holdQ     <= '0;
      csStrobeQ <= 1'b0;
      waitEnQ   <= 1'b0;
      waitMeta  <= 1'b0;
      waitSync  <= 1'b0;
      rdQ       <= '0;
    end else begin
      waitMeta <= memWait;
      waitSync <= waitMeta;
      if (ctl.load) begin
        writeQ    <= reqWrite;
        csQ       <= reqCs;
        addrQ     <= reqAddr;
        wdataQ    <= reqWdata;
        setupQ    <= selSetup;
        strobeQ   <= selStrobe;
        holdQ     <= selHold;
        csStrobeQ <= selCsStrobe;
        waitEnQ   <= selWaitEn;
      end
      if (ctl.capture && !writeQ) begin
        rdQ <= memDataIn;
      end
    end
  end

  assign stall     = waitEnQ && (waitSync == waitPol);
  assign curWrite  = writeQ;
  assign curCs     = csQ;
  assign curSetup  = setupQ;
  assign curStrobe = strobeQ;
  assign curHold   = holdQ;
  assign rdData    = rdQ;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign memCsN[g] = !(ctl.active && (csQ == CS_W'(g)) && (!csStrobeQ || ctl.strobeOn));
  end

  assign memAddr    = addrQ;
  assign memOeN     = !(ctl.strobeOn && !writeQ);
  assign memWeN     = !(ctl.strobeOn && writeQ);
  assign memDataOut = wdataQ;
  assign memDataOe  = ctl.active && writeQ;

endmodule

// File: rtl/amem_cycle_ctrl.sv
module amem_cycle_ctrl
  import amem_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 4,
  parameter int TA_W    = 3,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int CFG_W  = 6 * FIELD_W + TA_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CS*CFG_W-1:0] cfgWord,
  input  logic                    waitPol,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [CS_W-1:0]         reqCs,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    doneValid,
  output logic [DATA_W-1:0]       rdData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [NUM_CS-1:0]       memCsN,
  output logic                    memOeN,
  output logic                    memWeN,
  output logic [DATA_W-1:0]       memDataOut,
  output logic                    memDataOe,
  input  logic [DATA_W-1:0]       memDataIn,
  input  logic                    memWait
);
  dpCtl_t             ctl;
  logic [FIELD_W-1:0] selSetup, selStrobe, selHold;
  logic [TA_W-1:0]    selTurn;
  logic               selCsStrobe, selWaitEn;
  logic               curWrite;
  logic [CS_W-1:0]    curCs;
  logic [FIELD_W-1:0] curSetup, curStrobe, curHold;
  logic               stall;

  amem_cfg_sel #(
    .NUM_CS(NUM_CS), .FIELD_W(FIELD_W), .TA_W(TA_W)
  ) i_cfg_sel (
    .cfgWord (cfgWord),
    .selCs   (reqCs),
    .selWrite(reqWrite),
    .setupW  (selSetup),
    .strobeW (selStrobe),
    .holdW   (selHold),
    .turnW   (selTurn),
    .csStrobe(selCsStrobe),
    .waitEn  (selWaitEn)
  );

  amem_ctrl #(
    .FIELD_W(FIELD_W), .TA_W(TA_W), .CS_W(CS_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqCs    (reqCs),
    .newSetup (selSetup),
    .newTurn  (selTurn),
    .lastWrite(curWrite),
    .lastCs   (curCs),
    .curSetup (curSetup),
    .curStrobe(curStrobe),
    .curHold  (curHold),
    .stall    (stall),
    .reqReady (reqReady),
    .doneValid(doneValid),
    .ctl      (ctl)
  );

  amem_dp #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FIELD_W(FIELD_W), .CS_W(CS_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqWrite   (reqWrite),
    .reqCs      (reqCs),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .selSetup   (selSetup),
    .selStrobe  (selStrobe),
    .selHold    (selHold),
    .selCsStrobe(selCsStrobe),
    .selWaitEn  (selWaitEn),
    .waitPol    (waitPol),
    .memWait    (memWait),
    .memDataIn  (memDataIn),
    .curWrite   (curWrite),
    .curCs      (curCs),
    .curSetup   (curSetup),
    .curStrobe  (curStrobe),
    .curHold    (curHold),
    .stall      (stall),
    .rdData     (rdData),
    .memAddr    (memAddr),
    .memCsN     (memCsN),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe)
  );

endmodule

// File: rtl/amem_chk.sv
module amem_chk #(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              doneValid,
  input logic [NUM_CS-1:0] memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDataOe,
  input logic [DATA_W-1:0] memDataOut
);

  assert_one_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_strobe_has_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> !(&memCsN));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe);

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memDataOe && $past(memDataOe)) |-> $stable(memDataOut));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> reqReady);

  assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memOeN && memWeN && (&memCsN) && !memDataOe));

  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind amem_cycle_ctrl amem_chk #(
  .NUM_CS(NUM_CS), .DATA_W(DATA_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .doneValid (doneValid),
  .memCsN    (memCsN),
  .memOeN    (memOeN),
  .memWeN    (memWeN),
  .memDataOe (memDataOe),
  .memDataOut(memDataOut)
);

// File: tb/test_amem_cycle_ctrl.sv
module test_amem_cycle_ctrl;
  localparam int NCS   = 4;
  localparam int CFGW  = 29;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NCS*CFGW-1:0] cfgWord = '0;
  logic              waitPol = 1'b1;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [1:0]        reqCs = '0;
  logic [15:0]       reqAddr = '0;
  logic [15:0]       reqWdata = '0;
  logic              doneValid;
  logic [15:0]       rdData;
  logic [15:0]       memAddr;
  logic [NCS-1:0]    memCsN;
  logic              memOeN;
  logic              memWeN;
  logic [15:0]       memDataOut;
  logic              memDataOe;
  logic [15:0]       memDataIn;
  logic              memWait = 1'b0;

  int checks = 0;
  int failures = 0;
  bit bLastValid = 0;
  bit bLastWrite = 0;
  int bLastCs = 0;

  always #4 clk = ~clk;

  assign memDataIn = memAddr ^ KEY;

  amem_cycle_ctrl i_amem_cycle_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .waitPol(waitPol),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .doneValid(doneValid), .rdData(rdData), .memAddr(memAddr),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn), .memWait(memWait)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CFGW-1:0] mkWord(int rs, int rst, int rh, int ws, int wst,
                                             int wh, int ta, bit css, bit wen);
    return {wen, css, 3'(ta), 4'(wh), 4'(wst), 4'(ws), 4'(rh), 4'(rst), 4'(rs)};
  endfunction

  // Runs one access starting at a negedge; ends at a negedge one cycle after done.
  task automatic runAccess(input bit wr, input int cs, input logic [15:0] addr,
                           input logic [15:0] wd, input int relAt);
    logic [CFGW-1:0] w;
    int eS, eSt, eH, ta, expTurn, expStb, expCs;
    bit css, wen;
    int nTurn = 0, nSetup = 0, nStb = 0, nHold = 0, csLow = 0, stage = 0;
    bit seenDone = 0, readyBad = 0, otherBad = 0, pinBad = 0, dataBad = 0;
    w   = cfgWord[cs*CFGW +: CFGW];
    eS  = wr ? int'(w[15:12]) : int'(w[3:0]);
    eSt = wr ? int'(w[19:16]) : int'(w[7:4]);
    eH  = wr ? int'(w[23:20]) : int'(w[11:8]);
    ta  = int'(w[26:24]);
    css = w[27];
    wen = w[28];
    expTurn = (bLastValid && (wr != bLastWrite || cs != bLastCs)) ? ta + 1 : 0;
    expStb  = eSt + 1;
    if (wen && relAt > 0 && relAt + 2 > expStb) expStb = relAt + 2;
    expCs = css ? expStb : (eS + 1) + expStb + (eH + 1);

    check(reqReady == 1'b1, "R11 ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqCs = 2'(cs); reqAddr = addr; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 300; k++) begin
      bit stbNow, csNow, inAcc;
      if (k > 0) @(negedge clk);
      if (doneValid) begin seenDone = 1; break; end
      stbNow = wr ? !memWeN : !memOeN;
      csNow  = !memCsN[cs];
      inAcc  = csNow || memDataOe || stbNow;
      if (reqReady) readyBad = 1;
      for (int j = 0; j < NCS; j++) if (j != cs && !memCsN[j]) otherBad = 1;
      if (wr ? !memOeN : !memWeN) pinBad = 1;
      if (csNow) csLow++;
      if (stbNow) begin
        stage = 2; nStb++;
        if (relAt > 0 && nStb == relAt) memWait = ~waitPol;
      end else if (stage >= 2) begin
        stage = 3; nHold++;
      end else if (inAcc) begin
        stage = 1; nSetup++;
      end else begin
        nTurn++;
      end
      if (wr) begin
        if (memDataOe != (stage >= 1)) dataBad = 1;
        if (memDataOe && memDataOut != wd) dataBad = 1;
      end else if (memDataOe) dataBad = 1;
    end
    check(seenDone, "R11 done pulse seen", int'(seenDone), 1);
    check(nTurn == expTurn, "R8 turnaround cycles", nTurn, expTurn);
    check(nSetup == eS + 1, "R2 setup cycles", nSetup, eS + 1);
    check(nStb == expStb, wen ? "R9 stretched strobe cycles" : "R2 strobe cycles", nStb, expStb);
    check(nHold == eH + 1, "R2 hold cycles", nHold, eH + 1);
    check(csLow == expCs, css ? "R5 cs low cycles" : "R4 cs low cycles", csLow, expCs);
    check(!otherBad, "R4 other spaces idle", int'(otherBad), 0);
    check(!pinBad, "R2 opposite strobe idle", int'(pinBad), 0);
    check(!dataBad, "R6 write data drive", int'(dataBad), 0);
    check(!readyBad, "R11 ready low during access", int'(readyBad), 0);
    check(reqReady && (&memCsN) && memOeN && memWeN, "R11 idle at done", int'(reqReady), 1);
    if (!wr) check(rdData == (addr ^ KEY), "R7 read data", int'(rdData), int'(addr ^ KEY));
    @(negedge clk);
    check(doneValid == 1'b0, "R11 done one cycle", int'(doneValid), 0);
    bLastValid = 1; bLastWrite = wr; bLastCs = cs;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // decoy words in every space (R3 independence)
    for (int c = 0; c < NCS; c++)
      cfgWord[c*CFGW +: CFGW] = mkWord(c + 1, c + 2, c, 7 - c, c + 3, 2, c + 4, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady && (&memCsN) && memOeN && memWeN && !memDataOe && !doneValid,
          "R1 state during reset", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && (&memCsN) && memOeN && memWeN && !memDataOe && !doneValid,
          "R1 state after reset", int'(reqReady), 1);

    // R2 R3 R4 R6 R7 R8: near-exhaustive width sweep, rotating over spaces
    begin
      int idx = 0;
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++)
            for (int c = 0; c < 3; c++) begin
              int s  = (a == 2) ? 3 : a;
              int st = (b == 2) ? 5 : b * 2;
              int h  = (c == 2) ? 4 : c;
              int cs = idx % NCS;
              cfgWord[cs*CFGW +: CFGW] = mkWord(s, st, h, h, st + 1, s, idx % 8, 1'b0, 1'b0);
              runAccess(d[0], cs, 16'(idx * 37 + 5), 16'(idx * 911) ^ 16'h00C3, 0);
              idx++;
            end
    end

    // R8: same-direction, same-space sequences skip turnaround
    cfgWord[2*CFGW +: CFGW] = mkWord(1, 2, 1, 0, 1, 2, 5, 1'b0, 1'b0);
    cfgWord[3*CFGW +: CFGW] = mkWord(2, 0, 0, 1, 3, 0, 2, 1'b0, 1'b0);
    runAccess(1'b0, 2, 16'h1111, 16'h0, 0);
    runAccess(1'b0, 2, 16'h1112, 16'h0, 0);
    runAccess(1'b1, 2, 16'h2222, 16'hBEEF, 0);
    runAccess(1'b1, 2, 16'h2223, 16'hCAFE, 0);
    runAccess(1'b1, 3, 16'h3333, 16'h1234, 0);
    runAccess(1'b0, 3, 16'h4444, 16'h0, 0);

    // R5: chip select as strobe (writes)
    cfgWord[1*CFGW +: CFGW] = mkWord(0, 0, 0, 2, 3, 1, 1, 1'b1, 1'b0);
    runAccess(1'b1, 1, 16'h5555, 16'hA5A5, 0);
    cfgWord[1*CFGW +: CFGW] = mkWord(0, 0, 0, 0, 0, 3, 0, 1'b1, 1'b0);
    runAccess(1'b1, 1, 16'h5556, 16'h5A5A, 0);

    // R9: extended wait, active-high then active-low
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 3; r++)
        for (int sIdx = 0; sIdx < 2; sIdx++) begin
          int rel = (r == 0) ? 1 : ((r == 1) ? 3 : 6);
          int stw = (sIdx == 0) ? 1 : 4;
          waitPol = (p == 0);
          memWait = waitPol;
          repeat (3) @(negedge clk);
          cfgWord[0*CFGW +: CFGW] = mkWord(1, stw, 1, 0, stw, 0, 0, 1'b0, 1'b1);
          runAccess(r[0], 0, 16'(16'h6000 + r * 2 + sIdx), 16'h7070, rel);
          memWait = ~waitPol;
        end

    // R10: wait pin held at wait level with wait disabled
    waitPol = 1'b1;
    memWait = 1'b1;
    repeat (3) @(negedge clk);
    cfgWord[0*CFGW +: CFGW] = mkWord(0, 2, 0, 1, 1, 1, 0, 1'b0, 1'b0);
    runAccess(1'b0, 0, 16'h7777, 16'h0, 0);
    runAccess(1'b1, 0, 16'h7778, 16'h9999, 0);
    memWait = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule